// File: doc/BRIEF.md
# Single and Double Word Shift Unit

This unit shifts 64-bit words in a two-stage pipeline. A single-word operation moves one operand left or right, dropping the bits that leave the word and filling with zeros. A double-word operation joins two operands into one 128-bit value, with the first operand as the upper half. It shifts that value and returns one 64-bit slice of it. In scalar mode a double-word operation may also wrap the bits that leave one end back in at the other end, so that the 128-bit value rotates.

The shift amount comes from a wide address-register value or from a short immediate field carried in the instruction. In vector mode the unit serves one element per clock. In that mode every shift drops bits and fills with zeros, and the amount always comes from the address-register value. A new operation may enter on every clock. Its result and a valid flag appear exactly two clocks later.

Top module: `dual_word_shifter`

## Requirements
- R1: An operation presented with `inValid` high on a rising edge shows its result, with `outValid` high, after the second rising edge that follows. Operations may enter on consecutive clocks, and `outValid` is low two edges after an edge with `inValid` low.
- R2: Single left (`inDouble`=0, `inLeft`=1) returns `opA` shifted left by n with zero fill, for n below 64.
- R3: Single right (`inDouble`=0, `inLeft`=0) returns `opA` shifted right by n with zero fill, for n below 64.
- R4: A single shift by 64 or more returns zero.
- R5: Double left returns bits 127..64 of {`opA`,`opB`} shifted left by n. `opA` is the upper half of the 128-bit value.
- R6: Double right returns bits 63..0 of {`opA`,`opB`} shifted right by n.
- R7: A double shift without wrapping returns zero when n is 128 or more.
- R8: When `inCirc`=1, a scalar double shift rotates the 128-bit value by n mod 128 before it takes the same slice as R5 or R6. A single shift ignores `inCirc`.
- R9: In scalar mode, `immSel`=1 takes n from the 7-bit `immCount`, and `immSel`=0 takes n from `addrCount`.
- R10: With `inVector`=1, `inCirc` and `immSel` are ignored. n always comes from `addrCount`, and every shift follows the zero-fill rules.
- R11: While reset is held, and after it is released, `outValid` and `outData` are 0 until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operation is presented |
| inLeft | input | 1 | 1 = shift left, 0 = shift right |
| inDouble | input | 1 | 1 = double-word (128-bit) shift |
| inCirc | input | 1 | Wrap the bits around (scalar double only) |
| inVector | input | 1 | Vector-element mode |
| immSel | input | 1 | 1 = amount from immCount |
| addrCount | input | CNT_W | Shift amount from an address register |
| immCount | input | 7 | Shift amount from the instruction field |
| opA | input | 64 | First operand (upper half of a double) |
| opB | input | 64 | Second operand (lower half of a double) |
| outValid | output | 1 | Result valid |
| outData | output | 64 | Result word |

## Verification
Vector mode can be requested in the same cycle as wrapping or as the immediate source. The bench sweeps every combination of the five mode bits, so vector mode is raised together with `inCirc` and `immSel` in the same operation. It judges the result against the zero-fill formula, with the amount taken from `addrCount`. The amounts are chosen so that `immCount` and `addrCount` differ, and so that a rotation would show bits that zero fill does not. Operations are issued back to back so that each stage holds a different mode in the same clock.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int WORD_W = 64;
  localparam int DBL_W  = 2 * WORD_W;
  localparam int AMT_W  = $clog2(DBL_W);

  typedef struct packed {
    logic             valid;
    logic             left;
    logic             dbl;
    logic             circ;
    logic             over;
    logic [AMT_W-1:0] amt;
  } shiftStrobe_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLeft,
  input  logic             inDouble,
  input  logic             inCirc,
  input  logic             inVector,
  input  logic             immSel,
  input  logic [CNT_W-1:0] addrCount,
  input  logic [AMT_W-1:0] immCount,
  output shiftStrobe_t     strobe,
  output logic             outValid
);
  localparam logic [CNT_W-1:0] SINGLE_LIM = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] DOUBLE_LIM = CNT_W'(DBL_W);

  logic [CNT_W-1:0] effCount;
  logic             circEff;
  logic             overEff;
  shiftStrobe_t     nextStrobe;

  always_comb begin
    effCount = (inVector || !immSel) ? addrCount : CNT_W'(immCount);
    circEff  = inCirc && inDouble && !inVector;
    overEff  = !circEff && (effCount >= (inDouble ? DOUBLE_LIM : SINGLE_LIM));
    nextStrobe.valid = inValid;
    nextStrobe.left  = inLeft;
    nextStrobe.dbl   = inDouble;
    nextStrobe.circ  = circEff;
    nextStrobe.over  = overEff;
    nextStrobe.amt   = effCount[AMT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe   <= '0;
      outValid <= 1'b0;
    end else begin
      strobe   <= nextStrobe;
      outValid <= strobe.valid;
    end
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  shiftStrobe_t      strobe,
  output logic [WORD_W-1:0] outData
);
  logic [WORD_W-1:0] regA, regB;
  logic [AMT_W:0][DBL_W-1:0] stg;
  logic [WORD_W-1:0] window;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      regA <= opA;
      regB <= opB;
    end
  end

  assign stg[0] = strobe.dbl  ? {regA, regB} :
                  strobe.left ? {regA, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, regA};

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [DBL_W-1:0] leftVal, rightVal;
    assign leftVal  = {stg[i][DBL_W-1-S:0],
                       (strobe.circ ? stg[i][DBL_W-1 -: S] : {S{1'b0}})};
    assign rightVal = {(strobe.circ ? stg[i][S-1:0] : {S{1'b0}}),
                       stg[i][DBL_W-1:S]};
    assign stg[i+1] = !strobe.amt[i] ? stg[i] : (strobe.left ? leftVal : rightVal);
  end

  assign window = strobe.left ? stg[AMT_W][DBL_W-1:WORD_W] : stg[AMT_W][WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outData <= '0;
    else if (strobe.valid) outData <= strobe.over ? '0 : window;
  end
endmodule

// File: rtl/dual_word_shifter.sv
module dual_word_shifter
  import shifter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLeft,
  input  logic              inDouble,
  input  logic              inCirc,
  input  logic              inVector,
  input  logic              immSel,
  input  logic [CNT_W-1:0]  addrCount,
  input  logic [AMT_W-1:0]  immCount,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);
  shiftStrobe_t strobe;

  shift_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLeft(inLeft),
    .inDouble(inDouble), .inCirc(inCirc), .inVector(inVector),
    .immSel(immSel), .addrCount(addrCount), .immCount(immCount),
    .strobe(strobe), .outValid(outValid)
  );

  shift_datapath u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .strobe(strobe), .outData(outData)
  );
endmodule

// File: rtl/dual_word_shifter_checker.sv
module dual_word_shifter_checker
  import shifter_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inLeft,
  input logic              inDouble,
  input logic              inCirc,
  input logic              inVector,
  input logic              immSel,
  input logic [CNT_W-1:0]  addrCount,
  input logic [AMT_W-1:0]  immCount,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              outValid,
  input logic [WORD_W-1:0] outData
);
  logic [CNT_W-1:0] n;
  logic singleBig, doubleBig, fullRot, vecBig;
  logic [1:0] vP, sbP, dbP, frP, vbP;
  logic [WORD_W-1:0] aP0, aP1;

  always_comb begin
    n = (inVector || !immSel) ? addrCount : CNT_W'(immCount);
    singleBig = inValid && !inDouble && (n >= CNT_W'(WORD_W));
    doubleBig = inValid && inDouble && !(inCirc && !inVector) && (n >= CNT_W'(DBL_W));
    fullRot   = inValid && inDouble && inCirc && !inVector && inLeft &&
                (n[AMT_W-1:0] == '0);
    vecBig    = inValid && inVector && inDouble && inCirc && (n >= CNT_W'(DBL_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vP <= '0; sbP <= '0; dbP <= '0; frP <= '0; vbP <= '0;
      aP0 <= '0; aP1 <= '0;
    end else begin
      vP  <= {vP[0], inValid};
      sbP <= {sbP[0], singleBig};
      dbP <= {dbP[0], doubleBig};
      frP <= {frP[0], fullRot};
      vbP <= {vbP[0], vecBig};
      aP0 <= opA;
      aP1 <= aP0;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vP[1]);
  p_single_over_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sbP[1]) |-> (outData == '0));
  p_double_over_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dbP[1]) |-> (outData == '0));
  p_full_rotate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && frP[1]) |-> (outData == aP1));
  p_vector_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && vbP[1]) |-> (outData == '0));
  always_comb begin
    if (!rstN) p_reset_r11: assert (outData == '0 && !outValid);
  end
endmodule

bind dual_word_shifter dual_word_shifter_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_word_shifter_test.sv
module dual_word_shifter_test;
  localparam int CNT_W = 16;
  logic clk = 0, rstN = 0;
  logic inValid = 0, inLeft = 0, inDouble = 0, inCirc = 0, inVector = 0, immSel = 0;
  logic [CNT_W-1:0] addrCount = '0;
  logic [6:0] immCount = '0;
  logic [63:0] opA = '0, opB = '0;
  logic outValid;
  logic [63:0] outData;

  int total = 0, bad = 0;
  logic expV [0:1];
  logic [63:0] expD [0:1];
  string expT [0:1];

  dual_word_shifter #(.CNT_W(CNT_W)) uut (.*);

  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
      input logic l, input logic d, input logic c, input logic v, input logic s,
      input logic [CNT_W-1:0] ac, input logic [6:0] ic);
    logic [127:0] x, r;
    int n, k;
    n = (v || !s) ? int'(ac) : int'(ic);
    if (!d) begin
      if (n >= 64) return 64'd0;
      return l ? (a << n) : (a >> n);
    end
    x = {a, b};
    if (c && !v) begin
      k = n % 128;
      r = l ? ((x << k) | (x >> (128 - k))) : ((x >> k) | (x << (128 - k)));
    end else begin
      if (n >= 128) return 64'd0;
      r = l ? (x << n) : (x >> n);
    end
    return l ? r[127:64] : r[63:0];
  endfunction

  function automatic string tagOf(input logic l, input logic d, input logic c,
      input logic v, input logic s, input int n);
    if (v) return "R10";
    if (c) return "R8";
    if (s) return "R9";
    if (!d) return (n >= 64) ? "R4" : (l ? "R2" : "R3");
    return (n >= 128) ? "R7" : (l ? "R5" : "R6");
  endfunction

  task automatic step(input logic vld, input logic l, input logic d, input logic c,
      input logic v, input logic s, input logic [CNT_W-1:0] ac, input logic [6:0] ic,
      input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    total++;
    if (outValid !== expV[1]) begin
      bad++;
      $display("FAIL R1: outValid actual=%0b expected=%0b", outValid, expV[1]);
    end else if (expV[1]) begin
      total++;
      if (outData !== expD[1]) begin
        bad++;
        $display("FAIL %s: outData actual=%h expected=%h", expT[1], outData, expD[1]);
      end
    end
    expV[1] = expV[0]; expD[1] = expD[0]; expT[1] = expT[0];
    expV[0] = vld;
    expD[0] = model(a, b, l, d, c, v, s, ac, ic);
    expT[0] = tagOf(l, d, c, v, s, (v || !s) ? int'(ac) : int'(ic));
    inValid = vld; inLeft = l; inDouble = d; inCirc = c; inVector = v; immSel = s;
    addrCount = ac; immCount = ic; opA = a; opB = b;
  endtask

  initial begin
    automatic int counts[14] = '{0, 1, 5, 31, 63, 64, 65, 100, 127, 128, 129, 200, 255, 300};
    automatic logic [63:0] pa[3] = '{64'h8123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001};
    automatic logic [63:0] pb[3] = '{64'hF0E1_D2C3_B4A5_9687, 64'h5555_AAAA_5555_AAAA, 64'h8000_0000_0000_0000};
    expV[0] = 0; expV[1] = 0; expD[0] = '0; expD[1] = '0; expT[0] = ""; expT[1] = "";
    repeat (3) @(negedge clk);
    total++;
    if (outValid !== 1'b0 || outData !== 64'd0) begin
      bad++;
      $display("FAIL R11: during reset actual=%0b/%h expected=0/0", outValid, outData);
    end
    rstN = 1;
    @(negedge clk);
    total++;
    if (outValid !== 1'b0 || outData !== 64'd0) begin
      bad++;
      $display("FAIL R11: after reset actual=%0b/%h expected=0/0", outValid, outData);
    end
    for (int m = 0; m < 32; m++) begin
      for (int ci = 0; ci < 14; ci++) begin
        for (int p = 0; p < 3; p++) begin
          // immediate differs from the address amount so source selection shows (R9, R10)
          step(1'b1, m[0], m[1], m[2], m[3], m[4], CNT_W'(counts[ci]),
               7'(counts[ci] * 3 + 7), pa[p], pb[p]);
        end
        // idle slot: outValid must drop two edges later (R1)
        if (ci == 6) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
      end
    end
    repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule